// File: doc/BRIEF.md
# Vector Destination Merge Under Tail and Mask Policy

This block is the last stage before a vector result is written back to the register file. It receives the previous contents of one 128-bit destination register, the freshly computed result for that register, a mask, the vector length, the start index and the element width. For every element it decides whether the element takes the new result, keeps its old value, or, when the element falls under an agnostic policy, is either filled with all ones or left as it was. It returns the merged register and one write-enable bit per element, one clock after the operation is presented.

A small configuration register holds a two-bit policy. The upper bit makes tail elements agnostic and the lower bit makes inactive (masked-off) body elements agnostic. The combination with only the lower bit set is not a valid configuration and raises an illegal flag. While that flag is set, every operation is refused: nothing is written and an illegal-instruction indication is returned with the result. The choice between ones and undisturbed for agnostic elements comes from an input on each operation, so consumers must accept either outcome.

Elements are numbered from the least significant end of the register. Elements whose index is below the start index are prestart elements, those at or above the vector length are tail elements, and the rest are body elements.

Top module: `vec_policy_wb`

## Requirements
- R1: After reset the stored policy reads 00. A configuration write stores both policy bits exactly as written, including 01, visible on the following cycle.
- R2: The illegal flag is set one cycle after a write of policy 01 and cleared by a write of any of 00, 10 or 11.
- R3: A body element that is active (index at or above the start index and below the vector length, with its mask bit 1 or masking disabled) takes the new result and has its write enable set.
- R4: A prestart element keeps its old value with its write enable clear, whatever the policy and the fill input.
- R5: Under policy 00, tail elements and inactive body elements keep their old value with their write enable clear.
- R6: Under policies 10 and 11, each tail element is either all ones with its write enable set (fill input 1) or its old value with its write enable clear (fill input 0); no other value is allowed. Under policy 10, inactive body elements keep their old value with their write enable clear.
- R7: Under policy 11, inactive body elements follow the same ones-or-old rule as agnostic tail elements.
- R8: While the illegal flag is set, an operation clears every element write enable, returns the old register unchanged and raises the illegal indication for that result.
- R9: The width code selects 8, 16, 32 or 64-bit elements for codes 0, 1, 2, 3, giving 16, 8, 4 or 2 elements; element i occupies bytes i*w through i*w+w-1 for w bytes per element, write-enable bit i belongs to element i, enable bits at or above the element count are 0, and an all-ones fill covers every byte of the element. Mask bit i belongs to element i.
- R10: A result appears with its valid flag exactly one cycle after an operation is presented; in a cycle after no operation, valid, all write enables and the illegal indication are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for the policy register |
| cfg_wpol | input | 2 | Policy value to store (bit 1 tail agnostic, bit 0 mask agnostic) |
| cfg_policy | output | 2 | Stored policy value |
| cfg_illegal | output | 1 | Illegal configuration flag |
| op_valid | input | 1 | Operation present this cycle |
| op_sew | input | 2 | Element width code |
| op_vl | input | 5 | Vector length in elements |
| op_vstart | input | 5 | Start element index |
| op_mask_en | input | 1 | Masking enabled |
| op_mask | input | 16 | Mask bit per element index |
| op_fill_ones | input | 1 | Agnostic elements get all ones (1) or stay undisturbed (0) |
| op_old | input | 128 | Previous destination register contents |
| op_new | input | 128 | Newly computed results |
| res_valid | output | 1 | Merged result valid |
| res_vd | output | 128 | Merged destination register |
| res_elem_we | output | 16 | Write enable per element index |
| res_illegal | output | 1 | Operation refused because of illegal configuration |

## Verification
On every cycle the assertions check that each result byte is the old byte, the new byte or all ones, that a refused operation writes nothing, that enable bits beyond the element count stay clear, that element 0 is never touched when the start index is nonzero, that idle cycles carry no enables, and that the policy register and illegal flag follow the last write. Which of the allowed values each element actually takes depends on its class: prestart, active, inactive body or tail under each policy, width and fill choice. Only the bench's scenarios, comparing every element against its own model, can show that, together with the edge cases of zero length, a start index past the length and a length beyond the element count.

// File: rtl/vpw_pkg.sv
package vpw_pkg;
  typedef enum logic [1:0] {
    CLS_PRESTART = 2'd0,
    CLS_ACTIVE   = 2'd1,
    CLS_KEEP     = 2'd2,
    CLS_AGNOSTIC = 2'd3
  } elem_cls_e;

  localparam logic [1:0] POL_BAD = 2'b01;
endpackage

// File: rtl/vpw_rst_sync.sv
module vpw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/vpw_cfg.sv
module vpw_cfg
  import vpw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_pol,
  output logic [1:0] pol_q,
  output logic       ill_q
);
  logic [1:0] pol_d;
  logic       ill_d;

  always_comb begin
    pol_d = pol_q;
    ill_d = ill_q;
    if (wr_en) begin
      pol_d = wr_pol;
      ill_d = (wr_pol == POL_BAD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= 2'b00;
      ill_q <= 1'b0;
    end else if (wr_en) begin
      pol_q <= pol_d;
      ill_q <= ill_d;
    end
  end
endmodule

// File: rtl/vpw_classify.sv
module vpw_classify
  import vpw_pkg::*;
#(
  parameter int NBYTE = 16,
  localparam int IDXW = $clog2(NBYTE),
  localparam int VLW  = IDXW + 1
) (
  input  logic [1:0]       sew,
  input  logic [VLW-1:0]   vl,
  input  logic [VLW-1:0]   vstart,
  input  logic             mask_en,
  input  logic [NBYTE-1:0] mask,
  input  logic [1:0]       pol,
  output elem_cls_e        cls [NBYTE]
);
  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    logic [IDXW-1:0] idx;
    logic [VLW-1:0]  idx_ext;

    assign idx     = IDXW'(b >> sew);
    assign idx_ext = {1'b0, idx};

    always_comb begin
      if (idx_ext < vstart)                 cls[b] = CLS_PRESTART;
      else if (idx_ext >= vl)               cls[b] = pol[1] ? CLS_AGNOSTIC : CLS_KEEP;
      else if (mask_en && !mask[idx])       cls[b] = pol[0] ? CLS_AGNOSTIC : CLS_KEEP;
      else                                  cls[b] = CLS_ACTIVE;
    end
  end
endmodule

// File: rtl/vpw_merge.sv
module vpw_merge
  import vpw_pkg::*;
#(
  parameter int NBYTE = 16
) (
  input  elem_cls_e          cls [NBYTE],
  input  logic               fill_ones,
  input  logic               refuse,
  input  logic [NBYTE*8-1:0] old_vd,
  input  logic [NBYTE*8-1:0] new_vd,
  output logic [NBYTE*8-1:0] out_vd,
  output logic [NBYTE-1:0]   byte_we
);
  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    always_comb begin
      out_vd[b*8 +: 8] = old_vd[b*8 +: 8];
      byte_we[b]       = 1'b0;
      if (!refuse) begin
        unique case (cls[b])
          CLS_ACTIVE: begin
            out_vd[b*8 +: 8] = new_vd[b*8 +: 8];
            byte_we[b]       = 1'b1;
          end
          CLS_AGNOSTIC: begin
            if (fill_ones) begin
              out_vd[b*8 +: 8] = 8'hFF;
              byte_we[b]       = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vec_policy_wb.sv
module vec_policy_wb
  import vpw_pkg::*;
#(
  parameter  int VLEN  = 128,
  localparam int NBYTE = VLEN / 8,
  localparam int IDXW  = $clog2(NBYTE),
  localparam int VLW   = IDXW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_wpol,
  output logic [1:0]       cfg_policy,
  output logic             cfg_illegal,
  input  logic             op_valid,
  input  logic [1:0]       op_sew,
  input  logic [VLW-1:0]   op_vl,
  input  logic [VLW-1:0]   op_vstart,
  input  logic             op_mask_en,
  input  logic [NBYTE-1:0] op_mask,
  input  logic             op_fill_ones,
  input  logic [VLEN-1:0]  op_old,
  input  logic [VLEN-1:0]  op_new,
  output logic             res_valid,
  output logic [VLEN-1:0]  res_vd,
  output logic [NBYTE-1:0] res_elem_we,
  output logic             res_illegal
);
  logic             rst_sync_n;
  elem_cls_e        cls [NBYTE];
  logic [VLEN-1:0]  merged;
  logic [NBYTE-1:0] byte_we;
  logic [NBYTE-1:0] elem_we_d;
  logic             valid_d;
  logic             illegal_d;
  logic [VLEN-1:0]  vd_d;
  logic [NBYTE-1:0] we_d;

  vpw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vpw_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (cfg_we),
    .wr_pol (cfg_wpol),
    .pol_q  (cfg_policy),
    .ill_q  (cfg_illegal)
  );

  vpw_classify #(.NBYTE(NBYTE)) u_cls (
    .sew     (op_sew),
    .vl      (op_vl),
    .vstart  (op_vstart),
    .mask_en (op_mask_en),
    .mask    (op_mask),
    .pol     (cfg_policy),
    .cls     (cls)
  );

  vpw_merge #(.NBYTE(NBYTE)) u_mrg (
    .cls       (cls),
    .fill_ones (op_fill_ones),
    .refuse    (cfg_illegal),
    .old_vd    (op_old),
    .new_vd    (op_new),
    .out_vd    (merged),
    .byte_we   (byte_we)
  );

  // Element enable taken from the lowest byte of each element.
  always_comb begin
    elem_we_d = '0;
    for (int i = 0; i < NBYTE; i++) begin
      if (i < (NBYTE >> op_sew)) elem_we_d[i] = byte_we[IDXW'(i << op_sew)];
    end
  end

  always_comb begin
    valid_d   = op_valid;
    illegal_d = op_valid & cfg_illegal;
    we_d      = op_valid ? elem_we_d : '0;
    vd_d      = op_valid ? merged : res_vd;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_valid   <= 1'b0;
      res_illegal <= 1'b0;
      res_elem_we <= '0;
    end else begin
      res_valid   <= valid_d;
      res_illegal <= illegal_d;
      res_elem_we <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   res_vd <= '0;
    else if (op_valid) res_vd <= vd_d;
  end
endmodule

// File: rtl/vpw_checker.sv
module vpw_checker #(
  parameter  int VLEN  = 128,
  localparam int NBYTE = VLEN / 8,
  localparam int VLW   = $clog2(NBYTE) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [1:0]       cfg_wpol,
  input logic [1:0]       cfg_policy,
  input logic             cfg_illegal,
  input logic             op_valid,
  input logic [1:0]       op_sew,
  input logic [VLW-1:0]   op_vstart,
  input logic [VLEN-1:0]  op_old,
  input logic [VLEN-1:0]  op_new,
  input logic             res_valid,
  input logic [VLEN-1:0]  res_vd,
  input logic [NBYTE-1:0] res_elem_we,
  input logic             res_illegal
);
  function automatic logic bytes_allowed(logic [VLEN-1:0] o, logic [VLEN-1:0] n,
                                         logic [VLEN-1:0] r);
    logic ok = 1'b1;
    for (int b = 0; b < NBYTE; b++) begin
      if (r[b*8 +: 8] != o[b*8 +: 8] && r[b*8 +: 8] != n[b*8 +: 8] &&
          r[b*8 +: 8] != 8'hFF) ok = 1'b0;
    end
    return ok;
  endfunction

  assert_cfg_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we) |-> cfg_policy == $past(cfg_wpol));

  assert_illegal_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we) |-> cfg_illegal == ($past(cfg_wpol) == 2'b01));

  assert_byte_values_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> bytes_allowed($past(op_old), $past(op_new), res_vd));

  assert_prestart_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(op_vstart) != '0) |->
      (!res_elem_we[0] && res_vd[7:0] == $past(op_old[7:0])));

  assert_refuse_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_illegal |-> (res_elem_we == '0 && res_vd == $past(op_old)));

  assert_enable_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_elem_we >> (NBYTE >> $past(op_sew))) == '0));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(op_valid) |-> (!res_valid && res_elem_we == '0 && !res_illegal));
endmodule

bind vec_policy_wb vpw_checker #(.VLEN(VLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cfg_we      (cfg_we),
  .cfg_wpol    (cfg_wpol),
  .cfg_policy  (cfg_policy),
  .cfg_illegal (cfg_illegal),
  .op_valid    (op_valid),
  .op_sew      (op_sew),
  .op_vstart   (op_vstart),
  .op_old      (op_old),
  .op_new      (op_new),
  .res_valid   (res_valid),
  .res_vd      (res_vd),
  .res_elem_we (res_elem_we),
  .res_illegal (res_illegal)
);

// File: tb/vec_policy_wb_tb.sv
module vec_policy_wb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VB = 128;
  localparam int NB = VB / 8;
  localparam int LW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_wpol = 2'b00;
  logic [1:0]    cfg_policy;
  logic          cfg_illegal;
  logic          op_valid = 1'b0;
  logic [1:0]    op_sew = 2'd0;
  logic [LW-1:0] op_vl = '0;
  logic [LW-1:0] op_vstart = '0;
  logic          op_mask_en = 1'b0;
  logic [NB-1:0] op_mask = '0;
  logic          op_fill_ones = 1'b0;
  logic [VB-1:0] op_old = '0;
  logic [VB-1:0] op_new = '0;
  logic          res_valid;
  logic [VB-1:0] res_vd;
  logic [NB-1:0] res_elem_we;
  logic          res_illegal;

  int n_checks = 0;
  int n_fail = 0;
  logic [1:0] model_pol = 2'b00;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_policy_wb u_dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wpol = p;
    @(negedge clk);
    cfg_we = 1'b0;
    model_pol = p;
    check(cfg_policy == p, "R1", "policy readback", 128'(cfg_policy), 128'(p));
    check(cfg_illegal == (p == 2'b01), "R2", "illegal flag",
          128'(cfg_illegal), 128'(p == 2'b01));
  endtask

  task automatic run_op(input int sew, input int vl, input int vs, input bit men,
                        input logic [NB-1:0] m, input bit fill, input int seed);
    int cnt, w, cls;
    logic [63:0] a, o, n;
    bit we, all_new, all_old, all_ones;
    string req;
    @(negedge clk);
    op_valid = 1'b1; op_sew = 2'(sew); op_vl = LW'(vl); op_vstart = LW'(vs);
    op_mask_en = men; op_mask = m; op_fill_ones = fill;
    for (int b = 0; b < NB; b++) begin
      op_old[b*8 +: 8] = 8'(8'h10 + b + seed);
      op_new[b*8 +: 8] = 8'(8'h60 + b + seed);
    end
    @(negedge clk);
    op_valid = 1'b0;
    check(res_valid == 1'b1, "R10", "valid after op", 128'(res_valid), 128'(1));
    check(res_illegal == (model_pol == 2'b01), "R8", "illegal indication",
          128'(res_illegal), 128'(model_pol == 2'b01));
    cnt = NB >> sew;
    w = 1 << sew;
    for (int e = 0; e < NB; e++) begin
      if (e >= cnt) begin
        check(res_elem_we[e] == 1'b0, "R9", $sformatf("enable beyond count e%0d", e),
              128'(res_elem_we[e]), 128'(0));
        continue;
      end
      a = '0; o = '0; n = '0;
      all_new = 1; all_old = 1; all_ones = 1;
      for (int k = 0; k < w; k++) begin
        a[k*8 +: 8] = res_vd[(e*w+k)*8 +: 8];
        o[k*8 +: 8] = op_old[(e*w+k)*8 +: 8];
        n[k*8 +: 8] = op_new[(e*w+k)*8 +: 8];
        if (a[k*8 +: 8] != n[k*8 +: 8]) all_new = 0;
        if (a[k*8 +: 8] != o[k*8 +: 8]) all_old = 0;
        if (a[k*8 +: 8] != 8'hFF) all_ones = 0;
      end
      we = res_elem_we[e];
      // 0 prestart, 1 active, 2 keep tail, 3 keep body, 4 agn tail, 5 agn body
      if (e < vs) cls = 0;
      else if (e >= vl) cls = model_pol[1] ? 4 : 2;
      else if (men && !m[e]) cls = model_pol[0] ? 5 : 3;
      else cls = 1;
      if (model_pol == 2'b01) begin
        check(!we && all_old, "R8", $sformatf("refused e%0d we=%b", e, we), 128'(a), 128'(o));
      end else if (cls == 1) begin
        check(we && all_new, "R3", $sformatf("active e%0d we=%b", e, we), 128'(a), 128'(n));
      end else if (cls == 4 || cls == 5) begin
        req = (cls == 4) ? "R6" : "R7";
        check((we && all_ones) || (!we && all_old), req,
              $sformatf("agnostic e%0d we=%b (ones or old)", e, we), 128'(a), 128'(o));
      end else begin
        req = (cls == 0) ? "R4" : ((model_pol == 2'b00) ? "R5" : "R6");
        check(!we && all_old, req, $sformatf("undisturbed e%0d we=%b", e, we),
              128'(a), 128'(o));
      end
    end
    @(negedge clk);
    check(!res_valid && res_elem_we == '0 && !res_illegal, "R10", "idle quiet",
          128'({res_valid, res_elem_we, res_illegal}), 128'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cfg_policy == 2'b00, "R1", "reset policy", 128'(cfg_policy), 128'(0));
    check(!cfg_illegal, "R2", "reset illegal", 128'(cfg_illegal), 128'(0));
    check(!res_valid && res_elem_we == '0, "R10", "reset outputs",
          128'({res_valid, res_elem_we}), 128'(0));

    // Policy 00: masked body and tail undisturbed
    run_op(0, 10, 0, 1, 16'b1011_0110_1100_1011, 1, 1);
    run_op(1, 6, 2, 1, 16'h00A5, 1, 2);
    // Policy 10: tail agnostic, body mask undisturbed
    write_cfg(2'b10);
    run_op(0, 9, 0, 1, 16'h0F0F, 1, 3);
    run_op(0, 9, 0, 1, 16'h0F0F, 0, 4);
    run_op(2, 2, 1, 1, 16'h0000, 1, 5);
    // Policy 11: both agnostic
    write_cfg(2'b11);
    run_op(1, 7, 0, 1, 16'h0055, 1, 6);
    run_op(2, 3, 1, 1, 16'h0002, 0, 7);
    run_op(3, 1, 0, 0, 16'h0000, 1, 8);
    run_op(3, 2, 1, 1, 16'h0000, 1, 9);
    // Edge cases: zero length, start past length, length past count
    run_op(0, 0, 0, 0, 16'hFFFF, 1, 10);
    run_op(1, 3, 5, 0, 16'hFFFF, 1, 11);
    run_op(2, 16, 0, 0, 16'h0000, 1, 12);
    // Illegal encoding refuses work; legal write clears it
    write_cfg(2'b01);
    run_op(0, 16, 0, 0, 16'hFFFF, 1, 13);
    write_cfg(2'b00);
    run_op(3, 2, 0, 1, 16'h0001, 1, 14);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule